// File: doc/BRIEF.md
# Logic Analyzer Command Decoder

This block sits behind a UART receiver in a serial-controlled logic analyzer. It takes one received byte per valid cycle and splits the stream into frames. A frame is either a single opcode byte or an opcode followed by a four-byte payload. Single-byte frames give one-cycle command pulses: reset, run, identify and metadata. Five-byte frames load the capture configuration: the sample clock divider, the packed read/delay counts, the acquisition flags and the trigger mask, value and config words of each trigger stage.

The decoder answers an identify request by itself. It presents a four-byte identity string on a valid/ready byte output, and the transmit side of the UART consumes it. A small rate generator turns the loaded divider into a sample-enable pulse. The host resynchronises the decoder by sending a run of zero bytes. No partial frame can swallow five of them, so the stream is always back at a frame boundary afterwards.

Top module: `sla_cmd_decoder`

## Requirements
- R1: A byte received at a frame boundary with bit 7 clear is a complete one-byte command. With bit 7 set it opens a frame that takes exactly four further received bytes.
- R2: The one-byte opcodes 0x00 (reset), 0x01 (run), 0x02 (identify) and 0x04 (metadata) each raise their own pulse output for exactly one cycle, in the cycle after the clock edge that samples the byte. At most one pulse is high at a time.
- R3: The four payload bytes are assembled with the first received byte as bits 7:0 and the last as bits 31:24. No register changes until the edge that samples the fourth payload byte, and the new value is visible from the next cycle.
- R4: Opcode 0x80 loads `divider_o` with payload bits 23:0 and restarts the rate counter. With divider N, `sample_tick_o` is high for one cycle in every N+1, first N+1 cycles after the load. After reset N is 0 and the tick is high every cycle.
- R5: Opcode 0x81 loads `read_count_m1_o` from payload bits 31:16 and `delay_count_m1_o` from payload bits 15:0.
- R6: Opcode 0x82 loads the flags. Payload bit 0 is demux enable, bit 1 is filter enable, bits 5:2 are per-group disables (bit 2+g set disables 8-bit channel group g), and bit 8 is run-length encoding enable.
- R7: Opcodes 0xC0 to 0xCF address the trigger stages. Bits 5:2 give the stage and bits 1:0 give the word: 0 is mask, 1 is value, 2 is config. Stage s occupies bits 32s+31:32s of the matching flattened output.
- R8: Any other opcode is consumed with its length from R1 and changes no register and raises no pulse. This covers short opcodes other than 0x00, 0x01, 0x02 and 0x04, long opcodes 0x83 to 0xBF and 0xD0 to 0xFF, and word code 3 within 0xC0 to 0xCF.
- R9: Five consecutive 0x00 bytes leave the decoder at a frame boundary whatever partial frame came before them, so the next byte is decoded as an opcode.
- R10: An identify pulse while no reply is pending starts a reply of the bytes 0x31, 0x53, 0x4C, 0x4F in that order. Each byte is held on `tx_data_o` with `tx_valid_o` high until an edge with `tx_ready_i` high. An identify pulse while a reply is pending is ignored.
- R11: After reset all registers read zero, all pulses are low and `tx_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| rx_valid_i | input | 1 | A received byte is present this cycle |
| rx_data_i | input | 8 | Received byte |
| tx_valid_o | output | 1 | Identity reply byte available |
| tx_data_o | output | 8 | Identity reply byte |
| tx_ready_i | input | 1 | Transmitter takes the reply byte at this edge |
| cmd_reset_o | output | 1 | Reset command pulse |
| cmd_run_o | output | 1 | Run command pulse |
| cmd_id_o | output | 1 | Identify command pulse |
| cmd_meta_o | output | 1 | Metadata command pulse |
| divider_o | output | 24 | Sample clock divider N |
| sample_tick_o | output | 1 | Sample enable, once every N+1 cycles |
| read_count_m1_o | output | 16 | Read count minus one |
| delay_count_m1_o | output | 16 | Delay count minus one |
| grp_disable_o | output | 4 | Channel group disables, 1 = group off |
| demux_en_o | output | 1 | Demux enable |
| filter_en_o | output | 1 | Filter enable |
| rle_en_o | output | 1 | Run-length encoding enable |
| trig_mask_o | output | 128 | Trigger mask words, stage s at bits 32s+31:32s |
| trig_value_o | output | 128 | Trigger value words, same layout |
| trig_cfg_o | output | 128 | Trigger config words, same layout |

## Verification
The framing state is hidden, but an error in it shows at the ports within one frame. A wrong byte count makes the next opcode land on a payload position, so a later run or identify byte either gives no pulse or gives the wrong one. A misplaced register write makes a configuration output differ in the cycle after the fifth byte. A wrong payload byte order shows up as a byte-swapped value. A fault in the reply pointer or in its handshake puts a wrong or repeated character on the byte output at the next accepted transfer. A fault in the rate counter moves the sample tick within N+1 cycles of a divider load.

// File: rtl/sla_cmd_pkg.sv
// Shared opcodes, frame types and identity string for the command decoder.
// Assumes 8-bit received bytes and a fixed four-byte payload per long frame.
package sla_cmd_pkg;

    localparam int BYTE_W        = 8;
    localparam int PAYLOAD_BYTES = 4;
    localparam int WORD_W        = BYTE_W * PAYLOAD_BYTES;
    localparam int ID_LEN        = 4;

    localparam logic [7:0] OP_RESET = 8'h00;
    localparam logic [7:0] OP_RUN   = 8'h01;
    localparam logic [7:0] OP_ID    = 8'h02;
    localparam logic [7:0] OP_META  = 8'h04;
    localparam logic [7:0] OP_DIV   = 8'h80;
    localparam logic [7:0] OP_SIZE  = 8'h81;
    localparam logic [7:0] OP_FLAGS = 8'h82;

    // Word selector carried in opcode bits 1:0 of a trigger-stage frame
    typedef enum logic [1:0] {
        TK_MASK   = 2'd0,
        TK_VALUE  = 2'd1,
        TK_CONFIG = 2'd2,
        TK_NONE   = 2'd3
    } trig_kind_e;

    // Completed long frame, valid for the single cycle of its last byte
    typedef struct packed {
        logic              valid;
        logic [7:0]        opcode;
        logic [WORD_W-1:0] data;
    } long_cmd_t;

    // Registered one-cycle short-command pulses
    typedef struct packed {
        logic rst;
        logic run;
        logic id;
        logic meta;
    } short_cmd_t;

    // Identity reply character at transmit position idx
    function automatic logic [7:0] id_char(input logic [1:0] idx);
        case (idx)
            2'd0:    id_char = 8'h31;
            2'd1:    id_char = 8'h53;
            2'd2:    id_char = 8'h4C;
            default: id_char = 8'h4F;
        endcase
    endfunction

endpackage

// File: rtl/sla_frame_parser.sv
// Splits the received byte stream into one-byte and five-byte frames.
// Short frames become registered one-cycle pulses. Long frames collect their
// payload first byte lowest and are presented combinationally, together with
// the fourth payload byte, for the register bank to commit on that edge.
// Assumes the receiver supplies at most one byte per cycle with no back-pressure.
module sla_frame_parser
    import sla_cmd_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_n_i,
    input  logic       rx_valid_i,
    input  logic [7:0] rx_data_i,
    output long_cmd_t  long_o,
    output short_cmd_t short_o
);

    localparam int LEFT_W = $clog2(PAYLOAD_BYTES + 1);
    localparam int SH_W   = (PAYLOAD_BYTES - 1) * BYTE_W;

    logic              in_frame_q;
    logic [LEFT_W-1:0] left_q;
    logic [7:0]        op_q;
    logic [SH_W-1:0]   sh_q;
    short_cmd_t        short_q;
    logic [2:0]        zrun_q;

    // Present a finished long frame in the cycle its last byte arrives
    always_comb begin
        long_o.valid  = rx_valid_i && in_frame_q && (left_q == LEFT_W'(1));
        long_o.opcode = op_q;
        long_o.data   = {rx_data_i, sh_q};
    end

    assign short_o = short_q;

    // Frame tracking, payload shifting and short-command pulse generation
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            in_frame_q <= 1'b0;
            left_q     <= '0;
            op_q       <= '0;
            sh_q       <= '0;
            short_q    <= '0;
        end else begin
            short_q <= '0;
            if (rx_valid_i) begin
                if (!in_frame_q) begin
                    if (rx_data_i[7]) begin
                        in_frame_q <= 1'b1;
                        left_q     <= LEFT_W'(PAYLOAD_BYTES);
                        op_q       <= rx_data_i;
                    end else begin
                        short_q.rst  <= (rx_data_i == OP_RESET);
                        short_q.run  <= (rx_data_i == OP_RUN);
                        short_q.id   <= (rx_data_i == OP_ID);
                        short_q.meta <= (rx_data_i == OP_META);
                    end
                end else begin
                    sh_q   <= {rx_data_i, sh_q[SH_W-1:BYTE_W]};
                    left_q <= left_q - LEFT_W'(1);
                    if (left_q == LEFT_W'(1)) begin
                        in_frame_q <= 1'b0;
                    end
                end
            end
        end
    end

    // Count consecutive zero bytes (saturating) to watch the resync rule
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            zrun_q <= '0;
        end else if (rx_valid_i) begin
            if (rx_data_i != 8'h00)      zrun_q <= '0;
            else if (zrun_q != 3'd5)     zrun_q <= zrun_q + 3'd1;
        end
    end

    a_r9_resync_idle: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (zrun_q == 3'd5) |-> !in_frame_q);

    a_r2_one_pulse: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $onehot0({short_o.rst, short_o.run, short_o.id, short_o.meta}));

endmodule

// File: rtl/sla_cfg_regs.sv
// Configuration register bank written by completed long frames.
// Decodes the opcode, unpacks the count and flag fields and keeps one
// mask/value/config triple per trigger stage. Assumes NUM_STAGES <= 16.
module sla_cfg_regs
    import sla_cmd_pkg::*;
#(
    parameter int NUM_STAGES = 4,
    parameter int DIV_W      = 24,
    parameter int CNT_W      = 16
) (
    input  logic                         clk_i,
    input  logic                         rst_n_i,
    input  long_cmd_t                    cmd_i,
    output logic                         div_wr_o,
    output logic [DIV_W-1:0]             divider_o,
    output logic [CNT_W-1:0]             read_m1_o,
    output logic [CNT_W-1:0]             delay_m1_o,
    output logic [3:0]                   grp_disable_o,
    output logic                         demux_o,
    output logic                         filter_o,
    output logic                         rle_o,
    output logic [NUM_STAGES*WORD_W-1:0] trig_mask_o,
    output logic [NUM_STAGES*WORD_W-1:0] trig_value_o,
    output logic [NUM_STAGES*WORD_W-1:0] trig_cfg_o
);

    logic             size_wr, flags_wr, trig_sel;
    logic [3:0]       stage_f;
    trig_kind_e       kind_f;
    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] read_q, delay_q;
    logic [3:0]       grp_q;
    logic             demux_q, filter_q, rle_q;
    logic             unused_bits;

    // Opcode decode of the frame being committed this cycle
    always_comb begin
        div_wr_o = cmd_i.valid && (cmd_i.opcode == OP_DIV);
        size_wr  = cmd_i.valid && (cmd_i.opcode == OP_SIZE);
        flags_wr = cmd_i.valid && (cmd_i.opcode == OP_FLAGS);
        trig_sel = cmd_i.valid && (cmd_i.opcode[7:6] == 2'b11);
        stage_f  = cmd_i.opcode[5:2];
        kind_f   = trig_kind_e'(cmd_i.opcode[1:0]);
    end

    assign unused_bits = ^{cmd_i.data[WORD_W-1:9], cmd_i.data[7:6]};

    // Divider, capture counts and flags
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            div_q    <= '0;
            read_q   <= '0;
            delay_q  <= '0;
            grp_q    <= '0;
            demux_q  <= 1'b0;
            filter_q <= 1'b0;
            rle_q    <= 1'b0;
        end else begin
            if (div_wr_o) div_q <= cmd_i.data[DIV_W-1:0];
            if (size_wr) begin
                read_q  <= cmd_i.data[2*CNT_W-1:CNT_W];
                delay_q <= cmd_i.data[CNT_W-1:0];
            end
            if (flags_wr) begin
                demux_q  <= cmd_i.data[0];
                filter_q <= cmd_i.data[1];
                grp_q    <= cmd_i.data[5:2];
                rle_q    <= cmd_i.data[8];
            end
        end
    end

    assign divider_o     = div_q;
    assign read_m1_o     = read_q;
    assign delay_m1_o    = delay_q;
    assign grp_disable_o = grp_q;
    assign demux_o       = demux_q;
    assign filter_o      = filter_q;
    assign rle_o         = rle_q;

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
        logic              hit;
        logic [WORD_W-1:0] mask_q, value_q, cfg_q;

        assign hit = trig_sel && (stage_f == 4'(s));

        // Trigger words of stage s
        always_ff @(posedge clk_i) begin
            if (!rst_n_i) begin
                mask_q  <= '0;
                value_q <= '0;
                cfg_q   <= '0;
            end else if (hit) begin
                case (kind_f)
                    TK_MASK:   mask_q  <= cmd_i.data;
                    TK_VALUE:  value_q <= cmd_i.data;
                    TK_CONFIG: cfg_q   <= cmd_i.data;
                    default:   ;
                endcase
            end
        end

        assign trig_mask_o [s*WORD_W +: WORD_W] = mask_q;
        assign trig_value_o[s*WORD_W +: WORD_W] = value_q;
        assign trig_cfg_o  [s*WORD_W +: WORD_W] = cfg_q;
    end

    a_r3_no_partial_commit: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !cmd_i.valid |=> ($stable(div_q) && $stable(read_q) && $stable(delay_q)
                          && $stable(grp_q) && $stable(rle_q)
                          && $stable(trig_mask_o) && $stable(trig_cfg_o)));

endmodule

// File: rtl/sla_rate_tick.sv
// Sample-enable generator: one tick every divider+1 clocks.
// A divider load restarts the count so the new period starts cleanly.
module sla_rate_tick #(
    parameter int DIV_W = 24
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             div_wr_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_q;
    logic             tick_q;

    // Count base clocks and emit the tick when the period completes
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (div_wr_i) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (cnt_q >= div_i) begin
            cnt_q  <= '0;
            tick_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + DIV_W'(1);
            tick_q <= 1'b0;
        end
    end

    assign tick_o = tick_q;

    a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        cnt_q <= div_i);

endmodule

// File: rtl/sla_id_responder.sv
// Sends the four identity characters on a valid/ready byte output after an
// identify pulse. Requests that arrive while a reply is pending are dropped.
module sla_id_responder
    import sla_cmd_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_n_i,
    input  logic       req_i,
    output logic       tx_valid_o,
    output logic [7:0] tx_data_o,
    input  logic       tx_ready_i
);

    logic       busy_q;
    logic [1:0] idx_q;

    // Reply sequencing: start when idle, advance on each accepted byte
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
        end else if (busy_q) begin
            if (tx_ready_i) begin
                idx_q <= idx_q + 2'd1;
                if (idx_q == 2'(ID_LEN - 1)) busy_q <= 1'b0;
            end
        end else if (req_i) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
        end
    end

    assign tx_valid_o = busy_q;
    assign tx_data_o  = id_char(idx_q);

    a_r10_hold_until_taken: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

endmodule

// File: rtl/sla_cmd_decoder.sv
// Top of the command decoder: frame parser, configuration bank,
// sample-rate generator and identity responder.
// Assumes one received byte per cycle at most and a transmitter that
// may stall the reply indefinitely.
module sla_cmd_decoder
    import sla_cmd_pkg::*;
#(
    parameter int NUM_STAGES = 4,
    parameter int DIV_W      = 24,
    parameter int CNT_W      = 16
) (
    input  logic                         clk_i,
    input  logic                         rst_n_i,
    input  logic                         rx_valid_i,
    input  logic [7:0]                   rx_data_i,
    output logic                         tx_valid_o,
    output logic [7:0]                   tx_data_o,
    input  logic                         tx_ready_i,
    output logic                         cmd_reset_o,
    output logic                         cmd_run_o,
    output logic                         cmd_id_o,
    output logic                         cmd_meta_o,
    output logic [DIV_W-1:0]             divider_o,
    output logic                         sample_tick_o,
    output logic [CNT_W-1:0]             read_count_m1_o,
    output logic [CNT_W-1:0]             delay_count_m1_o,
    output logic [3:0]                   grp_disable_o,
    output logic                         demux_en_o,
    output logic                         filter_en_o,
    output logic                         rle_en_o,
    output logic [NUM_STAGES*WORD_W-1:0] trig_mask_o,
    output logic [NUM_STAGES*WORD_W-1:0] trig_value_o,
    output logic [NUM_STAGES*WORD_W-1:0] trig_cfg_o
);

    long_cmd_t  long_cmd;
    short_cmd_t short_cmd;
    logic       div_wr;

    sla_frame_parser u_parser (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .rx_valid_i (rx_valid_i),
        .rx_data_i  (rx_data_i),
        .long_o     (long_cmd),
        .short_o    (short_cmd)
    );

    sla_cfg_regs #(
        .NUM_STAGES (NUM_STAGES),
        .DIV_W      (DIV_W),
        .CNT_W      (CNT_W)
    ) u_regs (
        .clk_i         (clk_i),
        .rst_n_i       (rst_n_i),
        .cmd_i         (long_cmd),
        .div_wr_o      (div_wr),
        .divider_o     (divider_o),
        .read_m1_o     (read_count_m1_o),
        .delay_m1_o    (delay_count_m1_o),
        .grp_disable_o (grp_disable_o),
        .demux_o       (demux_en_o),
        .filter_o      (filter_en_o),
        .rle_o         (rle_en_o),
        .trig_mask_o   (trig_mask_o),
        .trig_value_o  (trig_value_o),
        .trig_cfg_o    (trig_cfg_o)
    );

    sla_rate_tick #(
        .DIV_W (DIV_W)
    ) u_tick (
        .clk_i    (clk_i),
        .rst_n_i  (rst_n_i),
        .div_wr_i (div_wr),
        .div_i    (divider_o),
        .tick_o   (sample_tick_o)
    );

    sla_id_responder u_id (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .req_i      (short_cmd.id),
        .tx_valid_o (tx_valid_o),
        .tx_data_o  (tx_data_o),
        .tx_ready_i (tx_ready_i)
    );

    assign cmd_reset_o = short_cmd.rst;
    assign cmd_run_o   = short_cmd.run;
    assign cmd_id_o    = short_cmd.id;
    assign cmd_meta_o  = short_cmd.meta;

endmodule

// File: tb/sla_cmd_decoder_tb.sv
module sla_cmd_decoder_tb_top;

    localparam int NS = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rx_valid = 1'b0;
    logic [7:0]   rx_data = 8'h00;
    logic         tx_ready = 1'b0;
    logic         tx_valid;
    logic [7:0]   tx_data;
    logic         p_rst, p_run, p_id, p_meta;
    logic [23:0]  divider;
    logic         tick;
    logic [15:0]  rd_m1, dl_m1;
    logic [3:0]   grp;
    logic         demux, filt, rle;
    logic [127:0] tmask, tvalue, tcfg;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sla_cmd_decoder dut_i (
        .clk_i(clk), .rst_n_i(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
        .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
        .cmd_reset_o(p_rst), .cmd_run_o(p_run), .cmd_id_o(p_id), .cmd_meta_o(p_meta),
        .divider_o(divider), .sample_tick_o(tick),
        .read_count_m1_o(rd_m1), .delay_count_m1_o(dl_m1),
        .grp_disable_o(grp), .demux_en_o(demux), .filter_en_o(filt), .rle_en_o(rle),
        .trig_mask_o(tmask), .trig_value_o(tvalue), .trig_cfg_o(tcfg)
    );

    // ---------------- reference model (behavioural) ----------------
    logic [7:0]  id_ref [4] = '{8'h31, 8'h53, 8'h4C, 8'h4F};
    int          m_left, m_idx, m_cnt;
    logic [7:0]  m_op;
    logic [31:0] m_pay;
    bit          m_busy;
    logic [3:0]  e_pulse;   // {rst, run, id, meta}
    logic [23:0] e_div;
    bit          e_tick;
    logic [15:0] e_rd, e_dl;
    logic [3:0]  e_grp;
    bit          e_demux, e_filt, e_rle;
    logic [31:0] e_mask [NS], e_val [NS], e_cfg [NS];

    always @(posedge clk) begin : model
        bit start_id;
        bit dw;
        int stg;
        if (!rst_n) begin
            m_left = 0; m_idx = 0; m_cnt = 0; m_busy = 0; m_op = 0; m_pay = 0;
            e_pulse = 0; e_div = 0; e_tick = 0; e_rd = 0; e_dl = 0; e_grp = 0;
            e_demux = 0; e_filt = 0; e_rle = 0;
            for (int s = 0; s < NS; s++) begin e_mask[s] = 0; e_val[s] = 0; e_cfg[s] = 0; end
        end else begin
            start_id = e_pulse[1] && !m_busy;
            if (m_busy && tx_ready) begin
                m_idx++;
                if (m_idx == 4) begin m_busy = 0; m_idx = 0; end
            end else if (start_id) begin
                m_busy = 1; m_idx = 0;
            end
            e_pulse = 0;
            dw = 0;
            if (rx_valid) begin
                if (m_left == 0) begin
                    if (rx_data >= 8'h80) begin
                        m_op = rx_data; m_left = 4; m_pay = 0;
                    end else begin
                        case (rx_data)
                            8'h00: e_pulse = 4'b1000;
                            8'h01: e_pulse = 4'b0100;
                            8'h02: e_pulse = 4'b0010;
                            8'h04: e_pulse = 4'b0001;
                            default: ;
                        endcase
                    end
                end else begin
                    m_pay = m_pay | (32'(rx_data) << (8 * (4 - m_left)));
                    m_left--;
                    if (m_left == 0) begin
                        if (m_op == 8'h80) begin e_div = m_pay[23:0]; dw = 1; end
                        else if (m_op == 8'h81) begin e_rd = m_pay[31:16]; e_dl = m_pay[15:0]; end
                        else if (m_op == 8'h82) begin
                            e_demux = m_pay[0]; e_filt = m_pay[1];
                            e_grp = m_pay[5:2]; e_rle = m_pay[8];
                        end else if (m_op[7:6] == 2'b11) begin
                            stg = int'(m_op[5:2]);
                            if (stg < NS) begin
                                if (m_op[1:0] == 2'd0) e_mask[stg] = m_pay;
                                if (m_op[1:0] == 2'd1) e_val[stg]  = m_pay;
                                if (m_op[1:0] == 2'd2) e_cfg[stg]  = m_pay;
                            end
                        end
                    end
                end
            end
            if (dw) begin m_cnt = 0; e_tick = 0; end
            else if (m_cnt >= int'(e_div)) begin m_cnt = 0; e_tick = 1; end
            else begin m_cnt++; e_tick = 0; end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every output with the model on every clock (away from the edge)
    always @(negedge clk) begin
        if (rst_n) begin
            logic [127:0] xm, xv, xc;
            for (int s = 0; s < NS; s++) begin
                xm[s*32 +: 32] = e_mask[s];
                xv[s*32 +: 32] = e_val[s];
                xc[s*32 +: 32] = e_cfg[s];
            end
            chk("R2 pulses", {p_rst, p_run, p_id, p_meta}, e_pulse);
            chk("R4 divider/tick", {divider, tick}, {e_div, e_tick});
            chk("R5 counts", {rd_m1, dl_m1}, {e_rd, e_dl});
            chk("R6 flags", {grp, demux, filt, rle}, {e_grp, e_demux, e_filt, e_rle});
            chk("R7 trigger", tmask, xm);
            chk("R7 trigger", tvalue, xv);
            chk("R7 trigger", tcfg, xc);
            chk("R10 tx_valid", tx_valid, m_busy);
            if (m_busy) chk("R10 tx_data", tx_data, id_ref[m_idx]);
        end
    end

    // Send one byte; called at a negedge, returns at the next negedge
    task automatic send(input logic [7:0] b);
        rx_valid = 1'b1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic send_long(input logic [7:0] op, input logic [31:0] w);
        send(op);
        for (int i = 0; i < 4; i++) send(w[8*i +: 8]);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] got [4];
        int k, ticks;
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 reset", {tx_valid, p_rst, p_run, p_id, p_meta, divider, rd_m1, dl_m1, grp},
            '0);
        chk("R11 reset trig", tmask | tvalue | tcfg, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: run pulse lasts one cycle
        send(8'h01);
        chk("R2 run pulse", p_run, 1'b1);
        @(negedge clk);
        chk("R2 run pulse end", p_run, 1'b0);
        send(8'h04);
        chk("R2 meta pulse", p_meta, 1'b1);

        // R3/R4: divider, no commit before fifth byte
        send(8'h80); send(8'h03); send(8'h00); send(8'h00);
        chk("R3 no early commit", divider, 24'd0);
        send(8'h00);
        chk("R4 divider load", divider, 24'd3);
        ticks = 0;
        for (int i = 0; i < 12; i++) begin @(negedge clk); if (tick) ticks++; end
        chk("R4 tick count", ticks, 3);

        // R5, R6, R7
        send_long(8'h81, 32'h5678_1234);
        chk("R5 read count", rd_m1, 16'h5678);
        chk("R5 delay count", dl_m1, 16'h1234);
        send_long(8'h82, 32'h0000_012D);
        chk("R6 flags", {grp, demux, filt, rle}, {4'hB, 1'b1, 1'b0, 1'b1});
        send_long(8'hC0, 32'hDEAD_BEEF);
        chk("R7 stage0 mask", tmask[31:0], 32'hDEAD_BEEF);
        send_long(8'hCE, 32'h0000_0008);
        chk("R7 stage3 config", tcfg[127:96], 32'h0000_0008);
        send_long(8'hC9, 32'hA5A5_0F0F);
        chk("R7 stage2 value", tvalue[95:64], 32'hA5A5_0F0F);

        // R8/R1: unknown opcodes consumed with their length
        send_long(8'hC3, 32'hFFFF_FFFF);
        send_long(8'hD0, 32'h0101_0101);
        send_long(8'h9F, 32'h0202_0202);
        send(8'h11);
        chk("R8 unknown no change", {divider, rd_m1, dl_m1, tmask[31:0], tcfg[127:96]},
            {24'd3, 16'h5678, 16'h1234, 32'hDEAD_BEEF, 32'h8});
        send(8'h01);
        chk("R1 R8 framing after unknown", p_run, 1'b1);

        // R9: partial frame then five zeros
        send(8'h80); send(8'h55);
        chk("R3 partial frame", divider, 24'd3);
        for (int i = 0; i < 5; i++) send(8'h00);
        send(8'h01);
        chk("R9 resync run", p_run, 1'b1);

        // R10: identity reply with stalls, second request ignored
        tx_ready = 1'b0;
        send(8'h02);
        chk("R2 id pulse", p_id, 1'b1);
        @(negedge clk); @(negedge clk);
        chk("R10 hold first byte", {tx_valid, tx_data}, {1'b1, 8'h31});
        send(8'h02);
        @(negedge clk);
        tx_ready = 1'b1;
        k = 0;
        for (int i = 0; i < 8 && k < 4; i++) begin
            if (tx_valid) begin got[k] = tx_data; k++; end
            @(negedge clk);
        end
        tx_ready = 1'b0;
        chk("R10 reply", {got[0], got[1], got[2], got[3]}, {8'h31, 8'h53, 8'h4C, 8'h4F});
        repeat (3) @(negedge clk);
        chk("R10 request during reply ignored", tx_valid, 1'b0);

        // Mixed pseudo-random stream, compared each clock against the model
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tx_ready = lfsr[3];
            if (lfsr[0]) begin
                rx_valid = 1'b1;
                rx_data  = (lfsr[9:8] == 2'b00) ? {6'd0, lfsr[5:4]} : lfsr[15:8];
            end else begin
                rx_valid = 1'b0;
            end
            @(negedge clk);
        end
        rx_valid = 1'b0;
        repeat (10) @(negedge clk);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule